// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block receives two-channel serial audio as a slave. A bit clock, a word clock and a data line arrive from an external source and are sampled in a faster system clock. The receiver rebuilds one 24-bit sample per channel from each word-clock period and hands each finished stereo pair downstream with a one-cycle strobe. A static select input picks one of two framings. In the I2S framing the first data bit trails the word-clock change by one bit clock. In the left-justified framing the first data bit coincides with that change.

A second path measures how many bit clocks fall into each word-clock period. It raises an invalid-input flag when that count leaves the plausible range, so that the consumer can mute. This covers 24-bit to 64-bit slots at any sample rate from 32 kHz to 48 kHz. The flag also rises when the word clock stops toggling while the bit clock runs on.

A stereo pair is released when the next left slot begins, one bit clock after the last right bit has been captured. Both sample outputs then hold their value until the next strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held, and afterwards until the first pair completes, both sample outputs read zero and the pair strobe is low. The invalid flag reads 1 from reset until the first word-clock period has been measured.
- R2: With `fmt_lj` = 0 (I2S), a slot's MSB is the data bit taken on the second bit-clock rising edge after a word-clock transition. Word clock low marks the left slot and high marks the right slot.
- R3: With `fmt_lj` = 1 (left-justified), a slot's MSB is the data bit taken on the first bit-clock rising edge after a word-clock transition. Word clock high marks the left slot and low marks the right slot.
- R4: Data is MSB first. A slot longer than 24 bits keeps its first 24 bits and discards the rest.
- R5: A slot shorter than 24 bits is placed in the upper bits of the sample, and the missing low bits are zero.
- R6: `pair_valid` pulses for exactly one system clock when a left slot starts after a captured right slot. `left_data` and `right_data` change only in that cycle.
- R7: A pair is released only when a complete left slot is followed by a complete right slot. A partial slot seen after reset never produces a strobe, so the number of strobes equals the number of whole frames sent.
- R8: At each word-clock rising edge, `frame_bad` is set to 1 if the bit-clock rising edges counted since the previous word-clock rising edge number fewer than 48 or more than 128. Otherwise it is set to 0. Counts of exactly 48 and exactly 128 are valid.
- R9: Once 129 bit-clock rising edges have passed without a word-clock rising edge, `frame_bad` goes to 1 without waiting for the period to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_lj | input | 1 | Framing select: 0 = I2S, 1 = left-justified (static) |
| sck | input | 1 | Serial bit clock from the source |
| ws | input | 1 | Word clock (left/right select) from the source |
| sd | input | 1 | Serial data, sampled on bit-clock rising edges |
| left_data | output | 24 | Left sample of the last completed pair |
| right_data | output | 24 | Right sample of the last completed pair |
| pair_valid | output | 1 | One-cycle strobe for a new pair |
| frame_bad | output | 1 | Invalid-input flag from the word-clock period check |

## Verification
The embedded properties check on every cycle that the bit-clock edge detector never fires twice in a row and that the strobe is a single cycle. They also check that the sample outputs hold still between strobes, that a strobe always consumes a pending left sample, and that the invalid flag follows the period count at its limits. Only the bench scenarios can show that the right bits land in the right channel under each framing. The same holds for truncation and zero fill, for the exact number of pairs delivered, and for the flag's behaviour at the 48, 128 and 129 boundaries and when the word clock stalls.

// File: rtl/sar_pkg.sv
// Shared types for the serial audio receiver.
// Assumes: one bit-clock event record is produced per system clock.
package sar_pkg;

    // One sampled view of the serial bus, valid in the cycle after synchronisation
    typedef struct packed {
        logic rise;   // bit clock rose in this cycle
        logic ws;     // word clock level at that rise
        logic sd;     // data level at that rise
    } bit_evt_t;

endpackage

// File: rtl/sar_sync.sv
// Brings the three serial lines into the system clock domain and detects
// bit-clock rising edges. Assumes each bit-clock phase lasts at least
// two system clocks, and that word clock and data are stable around the
// bit-clock rising edge, so all three lines cross with the same latency.
module sar_sync #(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_in,
    input  logic              ws_in,
    input  logic              sd_in,
    output sar_pkg::bit_evt_t evt
);
    localparam int NLINES = 3;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic              sck_prev;

    assign raw = {sck_in, ws_in, sd_in};

    generate
        for (genvar g = 0; g < NLINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            // Shift one line through its synchroniser chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate

    // Register the edge event together with the word clock and data levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            evt      <= '0;
        end else begin
            sck_prev <= synced[2];
            evt.rise <= synced[2] & ~sck_prev;
            evt.ws   <= synced[1];
            evt.sd   <= synced[0];
        end
    end

    // R2/R3: a bit-clock rise is a single-cycle event
    a_r2_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        evt.rise |=> !evt.rise);

endmodule

// File: rtl/sar_deser.sv
// Slot framing and deserialisation. Finds slot starts from word-clock
// transitions, with a one-bit delay in I2S framing and none in
// left-justified framing. Fills a sample MSB first and releases a stereo
// pair when the following left slot begins.
// Assumes: fmt_lj is static while data flows; slots are at least two bits.
module sar_deser #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_lj,
    input  sar_pkg::bit_evt_t   evt,
    output logic [SAMPLE_W-1:0] left_data,
    output logic [SAMPLE_W-1:0] right_data,
    output logic                pair_valid
);
    localparam logic [SAMPLE_W-1:0] PTR_SECOND = {2'b01, {(SAMPLE_W-2){1'b0}}};

    logic                ws_last;    // word clock at the previous rise
    logic                chg_d;      // word clock changed at the previous rise
    logic                active;     // a slot start has been seen since reset
    logic                slot_left;  // slot being filled belongs to the left channel
    logic                left_ok;    // a complete left sample is waiting
    logic [SAMPLE_W-1:0] acc;        // sample under construction
    logic [SAMPLE_W-1:0] ptr;        // one-hot position of the next bit, zero when full
    logic [SAMPLE_W-1:0] left_hold;  // captured left sample awaiting its partner
    logic                chg;
    logic                start;

    assign chg   = evt.ws ^ ws_last;
    assign start = fmt_lj ? chg : chg_d;

    // Track framing, fill the sample and release pairs on slot boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_last    <= 1'b0;
            chg_d      <= 1'b0;
            active     <= 1'b0;
            slot_left  <= 1'b0;
            left_ok    <= 1'b0;
            acc        <= '0;
            ptr        <= '0;
            left_hold  <= '0;
            left_data  <= '0;
            right_data <= '0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (evt.rise) begin
                ws_last <= evt.ws;
                chg_d   <= chg;
                if (start) begin
                    if (active) begin
                        if (slot_left) begin
                            left_hold <= acc;
                            left_ok   <= 1'b1;
                        end else begin
                            if (left_ok) begin
                                left_data  <= left_hold;
                                right_data <= acc;
                                pair_valid <= 1'b1;
                            end
                            left_ok <= 1'b0;
                        end
                    end
                    active    <= 1'b1;
                    slot_left <= fmt_lj ? evt.ws : ~evt.ws;
                    acc       <= {evt.sd, {(SAMPLE_W-1){1'b0}}};
                    ptr       <= PTR_SECOND;
                end else begin
                    acc <= evt.sd ? (acc | ptr) : acc;
                    ptr <= ptr >> 1;
                end
            end
        end
    end

    // R4/R5: at most one bit position is pending at a time
    a_r4_ptr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ptr));

    // R6: strobe lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R6: outputs move only with the strobe
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> ($stable(left_data) && $stable(right_data)));

    // R7: every strobe consumes a pending left sample
    a_r7_left_first: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> ($past(left_ok) && !left_ok));

endmodule

// File: rtl/sar_frame_mon.sv
// Word-clock period monitor. Counts bit-clock rises between word-clock
// rising edges and flags periods outside [MIN_BCLK, MAX_BCLK]. Flags at
// once when the count passes MAX_BCLK with no word-clock edge.
// Assumes: the flag starts set until one full period has been measured.
module sar_frame_mon #(
    parameter int MIN_BCLK = 48,
    parameter int MAX_BCLK = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sar_pkg::bit_evt_t evt,
    output logic              frame_bad
);
    localparam int CW = $clog2(MAX_BCLK + 2);
    localparam logic [CW-1:0] CMIN  = CW'(MIN_BCLK);
    localparam logic [CW-1:0] CMAX  = CW'(MAX_BCLK);
    localparam logic [CW-1:0] COVER = CW'(MAX_BCLK + 1);

    logic          ws_prev;
    logic          have_ref;
    logic [CW-1:0] cnt;
    logic          ws_up;

    assign ws_up = evt.rise & evt.ws & ~ws_prev;

    // Count rises per period and judge each period at its end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_prev   <= 1'b0;
            have_ref  <= 1'b0;
            cnt       <= '0;
            frame_bad <= 1'b1;
        end else if (evt.rise) begin
            ws_prev <= evt.ws;
            if (ws_up) begin
                if (have_ref) frame_bad <= (cnt < CMIN) || (cnt > CMAX);
                have_ref <= 1'b1;
                cnt      <= CW'(1);
            end else if (have_ref && cnt <= CMAX) begin
                cnt <= cnt + CW'(1);
                if (cnt == CMAX) frame_bad <= 1'b1;
            end
        end
    end

    // R9: an overrun count is always reported
    a_r9_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == COVER) |-> frame_bad);

    // R8: an in-range period clears the flag
    a_r8_in_range_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ws_up && have_ref && cnt >= CMIN && cnt <= CMAX) |=> !frame_bad);

    // R8: a short period sets the flag
    a_r8_short_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ws_up && have_ref && cnt < CMIN) |=> frame_bad);

endmodule

// File: rtl/serial_audio_rx.sv
// Two-channel serial audio slave receiver with selectable I2S or
// left-justified framing and a word-clock period check for muting.
// Assumes: the system clock oversamples the bit clock so that each
// bit-clock phase spans at least SYNC_STAGES system clocks.
module serial_audio_rx #(
    parameter int SAMPLE_W    = 24,
    parameter int MIN_BCLK    = 48,
    parameter int MAX_BCLK    = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_lj,
    input  logic                sck,
    input  logic                ws,
    input  logic                sd,
    output logic [SAMPLE_W-1:0] left_data,
    output logic [SAMPLE_W-1:0] right_data,
    output logic                pair_valid,
    output logic                frame_bad
);
    sar_pkg::bit_evt_t evt;

    sar_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_in (sck),
        .ws_in  (ws),
        .sd_in  (sd),
        .evt    (evt)
    );

    sar_deser #(.SAMPLE_W(SAMPLE_W)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_lj     (fmt_lj),
        .evt        (evt),
        .left_data  (left_data),
        .right_data (right_data),
        .pair_valid (pair_valid)
    );

    sar_frame_mon #(.MIN_BCLK(MIN_BCLK), .MAX_BCLK(MAX_BCLK)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .frame_bad (frame_bad)
    );

endmodule

// File: tb/serial_audio_rx_test.sv
`timescale 1ns/1ps
module serial_audio_rx_test;
    localparam int H = 3;   // system clocks per bit-clock phase

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_lj = 1'b0;
    logic        sck = 1'b0;
    logic        ws = 1'b0;
    logic        sd = 1'b0;
    logic [23:0] left_data, right_data;
    logic        pair_valid, frame_bad;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R2";
    logic [47:0] exp_q[$];
    logic  pv_prev = 1'b0;

    always #2.5 clk = ~clk;

    serial_audio_rx uut (
        .clk(clk), .rst_n(rst_n), .fmt_lj(fmt_lj), .sck(sck), .ws(ws), .sd(sd),
        .left_data(left_data), .right_data(right_data),
        .pair_valid(pair_valid), .frame_bad(frame_bad)
    );

    task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    // Expected sample: first min(w,24) bits, zero filled below (R4, R5)
    function automatic logic [23:0] exp_word(input logic [23:0] d, input int w);
        if (w >= 24) return d;
        return d & ~((24'd1 << (24 - w)) - 24'd1);
    endfunction

    // Pair monitor: compares strobed pairs and checks single-cycle strobe (R6)
    always @(negedge clk) begin
        if (!done && rst_n) begin
            if (pv_prev) check("R6 strobe width", {47'd0, pair_valid}, 48'd0);
            if (pair_valid) begin
                if (exp_q.size() == 0) check({cur_req, " R7 unexpected pair"}, {left_data, right_data}, 48'hx);
                else check(cur_req, {left_data, right_data}, exp_q.pop_front());
            end
        end
        pv_prev <= pair_valid;
    end

    task automatic send_bit(input logic wsv, input logic b);
        @(negedge clk);
        sck = 1'b0; ws = wsv; sd = b;
        repeat (H) @(negedge clk);
        sck = 1'b1;
        repeat (H - 1) @(negedge clk);
    endtask

    // One slot; in I2S the word clock moves on the slot's last bit
    task automatic send_slot(input bit lj, input bit is_left, input logic [23:0] d, input int w);
        logic lvl;
        lvl = is_left ? lj : ~lj;
        for (int k = 0; k < w; k++) begin
            logic wsv, b;
            wsv = (!lj && k == w - 1) ? ~lvl : lvl;
            b = (k < 24) ? d[23 - k] : logic'($urandom % 2);
            send_bit(wsv, b);
        end
    endtask

    task automatic do_reset(input bit lj);
        @(negedge clk);
        rst_n = 1'b0; fmt_lj = lj; sck = 1'b0; ws = 1'b0; sd = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 samples after reset", {left_data, right_data}, 48'd0);
        check("R1 strobe/flag after reset", {46'd0, pair_valid, frame_bad}, 48'd1);
    endtask

    // Reset, partial slot, n whole frames, then a trailer frame that releases the last pair
    task automatic run(input bit lj, input int w, input int n, input bit bad_exp, input string req);
        logic [23:0] l, r;
        cur_req = req;
        do_reset(lj);
        send_slot(lj, 1'b0, 24'($urandom), 4);
        for (int f = 0; f < n; f++) begin
            l = 24'($urandom); r = 24'($urandom);
            exp_q.push_back({exp_word(l, w), exp_word(r, w)});
            send_slot(lj, 1'b1, l, w);
            send_slot(lj, 1'b0, r, w);
        end
        send_slot(lj, 1'b1, 24'($urandom), w);
        send_slot(lj, 1'b0, 24'($urandom), w);
        repeat (10) @(negedge clk);
        check({req, " R7 pairs outstanding"}, 48'(exp_q.size()), 48'd0);
        exp_q.delete();
        check({req, " R8 frame_bad"}, {47'd0, frame_bad}, {47'd0, bad_exp});
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20250611);
        run(1'b0, 32, 5, 1'b0, "R2 i2s w32");
        run(1'b1, 32, 5, 1'b0, "R3 lj w32");
        run(1'b0, 24, 5, 1'b0, "R8 i2s w24 min period");
        run(1'b1, 64, 4, 1'b0, "R4 lj w64 max period");
        run(1'b1, 16, 5, 1'b1, "R5 lj w16 short");
        run(1'b0, 20, 4, 1'b1, "R5 i2s w20 short");
        run(1'b0, 65, 3, 1'b1, "R4 i2s w65 long");
        run(1'b0, 23, 4, 1'b1, "R8 i2s w23 below min");
        // Stall: trailer leaves 64 rises counted; 64 more reach 128, one more overruns (R9)
        run(1'b1, 32, 3, 1'b0, "R9 lj before stall");
        for (int k = 0; k < 64; k++) send_bit(1'b0, logic'($urandom % 2));
        repeat (10) @(negedge clk);
        check("R9 count 128 still valid", {47'd0, frame_bad}, 48'd0);
        send_bit(1'b0, 1'b0);
        repeat (10) @(negedge clk);
        check("R9 count 129 flags", {47'd0, frame_bad}, 48'd1);
        // Constrained random framing and slot widths within the valid range
        for (int i = 0; i < 6; i++) begin
            bit lj_r;
            int w_r;
            lj_r = bit'($urandom % 2);
            w_r  = 24 + int'($urandom % 41);
            run(lj_r, w_r, 4, 1'b0, lj_r ? "R3 R4 random lj" : "R2 R4 random i2s");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog %s got=timeout expected=completion", cur_req);
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule